// File: doc/BRIEF.md
# Prime-Step and Shift Operation Unit

This unit accepts a small unsigned number each clock and, according to a selection bit, either steps it to a neighbouring prime or shifts it by one bit position. A direction bit chooses the step direction: toward larger values (next prime, left shift) or toward smaller values (previous prime, right shift). The input echo, the computed result, two decimal event counters and a warning flag are all registered outputs. They are updated on every rising clock edge.

The selection only takes effect when it agrees with the number's type. Prime stepping accepts only primes, and shifting accepts only non-primes. A disagreement raises the warning flag and freezes everything else. Each operation owns a private pair of decimal counters: one counts upward-direction events and one counts downward-direction events. On every accepted operation the shared count outputs show that operation's pair after its update. A synchronous clear input zeroes the outputs and both private pairs, and blocks any operation in that cycle.

Top module: `psu_unit`

## Requirements
- R1: After reset, all count outputs, both result outputs and the warning flag are zero, and both private counter pairs are zero.
- R2: Selection 0 with direction 1 on a prime input loads `step_val` with the smallest larger prime that fits in W bits. If none exists it loads the smallest prime, 2 (7 gives 11, 13 gives 2). `echo_val` receives the input. Results appear after the same clock edge.
- R3: Selection 0 with direction 0 on a prime input loads `step_val` with the largest smaller prime. For input 2 it wraps to the largest W-bit prime (13 when W=4; 7 gives 5).
- R4: Selection 1 with direction 1 on a non-prime input loads `step_val` with the input shifted left by one, with the top bit dropped and a 0 entering bit 0 (1010 gives 0100).
- R5: Selection 1 with direction 0 on a non-prime input loads `step_val` with the input shifted right by one, with a 0 entering the top bit (1010 gives 0101).
- R6: Each accepted operation with direction 1 increments the up counter of the selected operation's pair. With direction 0 it increments the down counter. Counters are decimal and wrap from 9 to 0. A repeated input counts again.
- R7: The prime operation (selection 0) and the shift operation (selection 1) keep separate counter pairs. After an accepted operation, `cnt_up` and `cnt_dn` show the selected operation's pair, even if the previous outputs showed the other pair.
- R8: 0 and 1 are non-prime; the primes for W=4 are 2, 3, 5, 7, 11 and 13. A non-prime with selection 0, or a prime with selection 1, sets `warn` to 1. In that case all count and result outputs and both private pairs hold their values.
- R9: `warn` returns to 0 on the first clock edge that has an accepted operation or an active clear.
- R10: With `clr` at 1, the next edge zeroes all four value outputs, `warn` and both private pairs, and no operation or warning takes place. This holds even when the input would otherwise be a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| num_in | input | W | Number to operate on |
| op_sel | input | 1 | 0 = prime step, 1 = shift |
| dir_mode | input | 1 | 1 = upward (next prime / left shift), 0 = downward |
| clr | input | 1 | Synchronous clear of outputs and both counter pairs |
| cnt_up | output | CW | Up-direction decimal counter of the last accepted operation |
| cnt_dn | output | CW | Down-direction decimal counter of the last accepted operation |
| step_val | output | W | Computed prime or shifted value |
| echo_val | output | W | Input number of the last accepted operation |
| warn | output | 1 | Type/selection mismatch flag |

## Verification
Clear and warning can both be triggered in the same cycle. A clear combined with a mismatched number, or with a selection change, must leave zeros and no warning, so clear always wins. The bench drives a prime with the shift selection while `clr` is high. It then shows that the next accepted operation counts from 1, which proves both private pairs were zeroed. A bank switch can also fall on the same edge as a counter wrap. The bench judges this by running one pair past 9 while the other pair is idle. It then checks that the idle pair's values reappear unchanged when its selection returns.

// File: rtl/psu_pkg.sv
package psu_pkg;

   localparam int MAX_W  = 8;
   localparam int MAX_N  = 1 << MAX_W;
   localparam int IDX_SH = 3;   // log2(MAX_W), table entry stride

   typedef enum logic {OP_PRIME = 1'b0, OP_SHIFT = 1'b1} op_e;
   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

   // Trial division; 0 and 1 are not prime.
   function automatic bit prime_chk(int v);
      bit ok;
      ok = (v >= 2);
      for (int d = 2; d < 16; d++) begin
         if (ok && d < v && (v % d) == 0) ok = 1'b0;
      end
      return ok;
   endfunction

   // Membership bit per value for a w-bit range.
   function automatic logic [MAX_N-1:0] prime_mask(int w);
      logic [MAX_N-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_N; i++) begin
         if (i < (1 << w)) m[i] = prime_chk(i);
      end
      return m;
   endfunction

   // Neighbour-prime table, MAX_W bits per entry, wrapping at the ends.
   function automatic logic [MAX_N*MAX_W-1:0] step_table(int w, bit up);
      logic [MAX_N*MAX_W-1:0] t;
      int n, lo, hi, pick;
      bit found;
      t  = '0;
      n  = 1 << w;
      lo = 0;
      hi = 0;
      for (int i = n - 1; i >= 0; i--) if (prime_chk(i)) lo = i;
      for (int i = 0; i < n; i++)      if (prime_chk(i)) hi = i;
      for (int i = 0; i < MAX_N; i++) begin
         if (i < n) begin
            found = 1'b0;
            pick  = up ? lo : hi;
            if (up) begin
               for (int j = 1; j < MAX_N; j++)
                  if (!found && (i + j) < n && prime_chk(i + j)) begin
                     pick  = i + j;
                     found = 1'b1;
                  end
            end else begin
               for (int j = 1; j < MAX_N; j++)
                  if (!found && (i - j) >= 0 && prime_chk(i - j)) begin
                     pick  = i - j;
                     found = 1'b1;
                  end
            end
            t[i*MAX_W +: MAX_W] = pick[MAX_W-1:0];
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/psu_classify.sv
module psu_classify
   import psu_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] num,
   output logic         is_prime,
   output logic [W-1:0] next_p,
   output logic [W-1:0] prev_p,
   output logic [W-1:0] shl,
   output logic [W-1:0] shr
);

   localparam logic [MAX_N-1:0]       PMASK = prime_mask(W);
   localparam logic [MAX_N*MAX_W-1:0] UP_T  = step_table(W, 1'b1);
   localparam logic [MAX_N*MAX_W-1:0] DN_T  = step_table(W, 1'b0);

   logic [W+IDX_SH-1:0] base;

   assign base     = {num, {IDX_SH{1'b0}}};
   assign is_prime = PMASK[num];
   assign next_p   = UP_T[base +: W];
   assign prev_p   = DN_T[base +: W];

   // Logical one-bit shifts with zero fill.
   assign shl = {num[W-2:0], 1'b0};
   assign shr = {1'b0, num[W-1:1]};

endmodule

// File: rtl/psu_bank.sv
module psu_bank #(
   parameter int CNT_MOD = 10,
   parameter int CW      = $clog2(CNT_MOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          up,
   output logic [CW-1:0] nxt_up,
   output logic [CW-1:0] nxt_dn
);

   logic [CW-1:0] up_q, dn_q, up_inc, dn_inc;

   // Wrap: free-running when the modulus is a power of two, compare otherwise.
   generate
      if ((1 << CW) == CNT_MOD) begin : g_pow2
         assign up_inc = up_q + 1'b1;
         assign dn_inc = dn_q + 1'b1;
      end else begin : g_cmp
         assign up_inc = (up_q == CW'(CNT_MOD - 1)) ? '0 : up_q + 1'b1;
         assign dn_inc = (dn_q == CW'(CNT_MOD - 1)) ? '0 : dn_q + 1'b1;
      end
   endgenerate

   assign nxt_up = (en &&  up) ? up_inc : up_q;
   assign nxt_dn = (en && !up) ? dn_inc : dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= '0;
         dn_q <= '0;
      end else if (clr) begin
         up_q <= '0;
         dn_q <= '0;
      end else begin
         up_q <= nxt_up;
         dn_q <= nxt_dn;
      end
   end

endmodule

// File: rtl/psu_unit.sv
module psu_unit
   import psu_pkg::*;
#(
   parameter int W       = 4,
   parameter int CNT_MOD = 10,
   parameter int CW      = $clog2(CNT_MOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  num_in,
   input  logic          op_sel,
   input  logic          dir_mode,
   input  logic          clr,
   output logic [CW-1:0] cnt_up,
   output logic [CW-1:0] cnt_dn,
   output logic [W-1:0]  step_val,
   output logic [W-1:0]  echo_val,
   output logic          warn
);

   localparam int NBANK = 2;

   generate
      if (W < 2 || W > MAX_W) begin : g_bad_w
         $error("psu_unit: W must be within 2..%0d", MAX_W);
      end
      if (CNT_MOD < 2 || CW < $clog2(CNT_MOD)) begin : g_bad_mod
         $error("psu_unit: CNT_MOD must be >= 2 and fit in CW bits");
      end
   endgenerate

   logic          is_p;
   logic [W-1:0]  nxt_p, prv_p, shl, shr, result;
   logic          type_ok, op_go, mism;
   logic [CW-1:0] bank_up [NBANK];
   logic [CW-1:0] bank_dn [NBANK];
   op_e           op;
   dir_e          dir;

   assign op  = op_e'(op_sel);
   assign dir = dir_e'(dir_mode);

   psu_classify #(.W(W)) u_cls (
      .num      (num_in),
      .is_prime (is_p),
      .next_p   (nxt_p),
      .prev_p   (prv_p),
      .shl      (shl),
      .shr      (shr)
   );

   assign type_ok = (op == OP_PRIME) ? is_p : !is_p;
   assign op_go   = !clr && type_ok;
   assign mism    = !clr && !type_ok;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         psu_bank #(.CNT_MOD(CNT_MOD), .CW(CW)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .en     (op_go && (op_sel == 1'(b))),
            .up     (dir == DIR_UP),
            .nxt_up (bank_up[b]),
            .nxt_dn (bank_dn[b])
         );
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_PRIME: result = (dir == DIR_UP) ? nxt_p : prv_p;
         OP_SHIFT: result = (dir == DIR_UP) ? shl   : shr;
         default:  result = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_up   <= '0;
         cnt_dn   <= '0;
         step_val <= '0;
         echo_val <= '0;
         warn     <= 1'b0;
      end else if (clr) begin
         cnt_up   <= '0;
         cnt_dn   <= '0;
         step_val <= '0;
         echo_val <= '0;
         warn     <= 1'b0;
      end else if (mism) begin
         warn     <= 1'b1;
      end else if (op_go) begin
         cnt_up   <= bank_up[op_sel];
         cnt_dn   <= bank_dn[op_sel];
         step_val <= result;
         echo_val <= num_in;
         warn     <= 1'b0;
      end
   end

endmodule

// File: rtl/psu_unit_chk.sv
module psu_unit_chk #(
   parameter int W       = 4,
   parameter int CNT_MOD = 10,
   parameter int CW      = $clog2(CNT_MOD)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [W-1:0]  num_in,
   input logic          op_sel,
   input logic          dir_mode,
   input logic          clr,
   input logic [CW-1:0] cnt_up,
   input logic [CW-1:0] cnt_dn,
   input logic [W-1:0]  step_val,
   input logic [W-1:0]  echo_val,
   input logic          warn
);

   // R10: clear zeroes everything on the next edge
   a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_up == '0 && cnt_dn == '0 && step_val == '0 && echo_val == '0 && !warn));

   // R8: a raised warning means the value outputs were held
   a_r8_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      warn |-> ($stable(cnt_up) && $stable(cnt_dn) && $stable(step_val) && $stable(echo_val)));

   // R4: accepted left shift
   a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op_sel && dir_mode) |=>
         (warn || (step_val == {$past(num_in[W-2:0]), 1'b0} && echo_val == $past(num_in))));

   // R5: accepted right shift
   a_r5_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op_sel && !dir_mode) |=>
         (warn || (step_val == {1'b0, $past(num_in[W-1:1])} && echo_val == $past(num_in))));

   // R2: accepted prime step echoes its input
   a_r2_prime_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !op_sel) |=> (warn || echo_val == $past(num_in)));

   // R6: counters stay decimal
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_up < CW'(CNT_MOD) && cnt_dn < CW'(CNT_MOD)));

endmodule

bind psu_unit psu_unit_chk #(.W(W), .CNT_MOD(CNT_MOD), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .num_in   (num_in),
   .op_sel   (op_sel),
   .dir_mode (dir_mode),
   .clr      (clr),
   .cnt_up   (cnt_up),
   .cnt_dn   (cnt_dn),
   .step_val (step_val),
   .echo_val (echo_val),
   .warn     (warn)
);

// File: tb/tb_psu_unit.sv
`timescale 1ns/1ps
module tb_psu_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] num_in = '0;
   logic       op_sel = 1'b0, dir_mode = 1'b0, clr = 1'b0;
   logic [3:0] cnt_up, cnt_dn, step_val, echo_val;
   logic       warn;

   int n_chk = 0, n_bad = 0;
   int eb_up [2];
   int eb_dn [2];
   int e_up, e_dn, e_step, e_echo, e_warn;

   always #4 clk = ~clk;   // 125 MHz

   psu_unit dut (
      .clk(clk), .rst_n(rst_n), .num_in(num_in), .op_sel(op_sel),
      .dir_mode(dir_mode), .clr(clr), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
      .step_val(step_val), .echo_val(echo_val), .warn(warn)
   );

   function automatic bit isp(int v);
      return v == 2 || v == 3 || v == 5 || v == 7 || v == 11 || v == 13;
   endfunction

   function automatic int nextp(int v);
      for (int k = v + 1; k < 16; k++) if (isp(k)) return k;
      return 2;
   endfunction

   function automatic int prevp(int v);
      for (int k = v - 1; k >= 0; k--) if (isp(k)) return k;
      return 13;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      eb_up = '{0, 0};
      eb_dn = '{0, 0};
      e_up = 0; e_dn = 0; e_step = 0; e_echo = 0; e_warn = 0;
   endtask

   task automatic cmp_all(string req);
      chk(req, "cnt_up",   cnt_up,   e_up);
      chk(req, "cnt_dn",   cnt_dn,   e_dn);
      chk(req, "step_val", step_val, e_step);
      chk(req, "echo_val", echo_val, e_echo);
      chk(req, "warn",     warn,     e_warn);
   endtask

   // One clock: drive at negedge, sample 1 ns after the rising edge.
   task automatic step(int n, bit s, bit m, bit c, string req);
      @(negedge clk);
      num_in = 4'(n); op_sel = s; dir_mode = m; clr = c;
      @(posedge clk);
      #1;
      if (c) model_clear();
      else if ((s == 1'b0) != isp(n)) e_warn = 1;
      else begin
         if (m) eb_up[s] = (eb_up[s] + 1) % 10;
         else   eb_dn[s] = (eb_dn[s] + 1) % 10;
         e_up = eb_up[s]; e_dn = eb_dn[s]; e_echo = n; e_warn = 0;
         if (s) e_step = m ? ((n << 1) & 15) : (n >> 1);
         else   e_step = m ? nextp(n) : prevp(n);
      end
      cmp_all(req);
   endtask

   task automatic lit(string req, int u, int d, int st, int ec, int w);
      chk(req, "lit cnt_up",   cnt_up,   u);
      chk(req, "lit cnt_dn",   cnt_dn,   d);
      chk(req, "lit step_val", step_val, st);
      chk(req, "lit echo_val", echo_val, ec);
      chk(req, "lit warn",     warn,     w);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      #1;
      lit("R1", 0, 0, 0, 0, 0);
   endtask

   task automatic t_sample();
      step(4'b1011, 0, 0, 0, "R3");  lit("R3", 0, 1, 7, 11, 0);
      step(4'b0111, 0, 1, 0, "R2");  lit("R2", 1, 1, 11, 7, 0);
      step(4'b0111, 1, 1, 0, "R8");  lit("R8", 1, 1, 11, 7, 1);
      step(4'b0110, 1, 1, 0, "R9");  lit("R9", 1, 0, 12, 6, 0);
      step(4'b0101, 0, 0, 0, "R7");  lit("R7", 1, 2, 3, 5, 0);
      step(4'b1111, 1, 1, 1, "R10"); lit("R10", 0, 0, 0, 0, 0);
   endtask

   task automatic t_prime_walk();
      for (int v = 2; v < 16; v++) if (isp(v)) begin
         step(v, 0, 1, 0, "R2");
         step(v, 0, 0, 0, "R3");
      end
      step(13, 0, 1, 0, "R2"); lit("R2 wrap", e_up, e_dn, 2, 13, 0);
      step(2, 0, 0, 0, "R3");  lit("R3 wrap", e_up, e_dn, 13, 2, 0);
   endtask

   task automatic t_shift();
      step(4'b1010, 1, 1, 0, "R4"); lit("R4", e_up, e_dn, 4'b0100, 10, 0);
      step(4'b1010, 1, 0, 0, "R5"); lit("R5", e_up, e_dn, 4'b0101, 10, 0);
      step(15, 1, 1, 0, "R4");
      step(15, 1, 0, 0, "R5");
      step(0, 1, 1, 0, "R4");
      step(1, 1, 0, 0, "R5");
   endtask

   task automatic t_wrap_and_banks();
      int keep_up, keep_dn;
      step(0, 1, 1, 1, "R10");
      step(3, 0, 0, 0, "R7");
      keep_up = eb_up[0]; keep_dn = eb_dn[0];
      for (int i = 0; i < 12; i++) step(4, 1, 1, 0, "R6");
      chk("R6", "wrapped up count", cnt_up, 2);
      step(5, 0, 1, 0, "R7");
      chk("R7", "prime pair restored dn", cnt_dn, keep_dn);
      chk("R7", "prime pair restored up", cnt_up, keep_up + 1);
   endtask

   task automatic t_mismatch();
      foreach (eb_up[i]) ;
      step(0, 0, 1, 0, "R8");
      step(1, 0, 0, 0, "R8");
      step(9, 0, 1, 0, "R8");
      step(15, 0, 0, 0, "R8");
      step(2, 1, 1, 0, "R8");
      step(13, 1, 0, 0, "R8");
      step(8, 1, 0, 0, "R9");
      chk("R9", "warn cleared", warn, 0);
   endtask

   task automatic t_clear_overlap();
      step(7, 0, 1, 0, "R10");
      step(8, 1, 0, 0, "R10");
      step(11, 1, 1, 1, "R10");
      step(6, 1, 0, 0, "R10");
      chk("R10", "shift dn after clear", cnt_dn, 1);
      chk("R10", "shift up after clear", cnt_up, 0);
      step(3, 0, 1, 0, "R10");
      chk("R10", "prime up after clear", cnt_up, 1);
      chk("R10", "prime dn after clear", cnt_dn, 0);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_sample();
      t_prime_walk();
      t_shift();
      t_wrap_and_banks();
      t_mismatch();
      t_clear_overlap();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule